// File: doc/BRIEF.md
# Guest Interrupt Tag Log Writer

This block appends guest interrupt tags to a circular log kept in system memory. Each incoming event carries a tag. While logging is on and the ring has room, the tag becomes one entry. The entry is written at the tail slot through a registered single-beat memory write port, and the tail then moves forward. Software drains the ring by moving the head pointer. The ring holds 2^PTR_W slots, and the tail wraps from the top slot back to slot 0.

A small register file controls the block. A control word holds the logging switch (bit 0) and the interrupt switch (bit 1). A status word holds the run flag (bit 0), the entry-written flag (bit 1) and the ring-overflow flag (bit 2). There are also words for the log base address, the head and the tail. An overflow discards the event and sets only the overflow flag; it never raises an interrupt. The interrupt line pulses only when the entry-written flag goes from 0 to 1. To relocate or rewind the ring, software clears the logging switch and waits for the run flag to fall. It then rewrites the base, head or tail and sets the switch again, choosing the interrupt switch in the same write.

Top module: `tglog_writer`

## Requirements
- R1: After reset, every register reads 0, no memory write is issued and the interrupt output is low.
- R2: An event accepted while logging is on issues exactly one memory write in the following cycle. Its address is base + tail × (DATA_W/8), its data is the tag zero-extended, and the tail then increments by one.
- R3: After the entry in the last slot (2^PTR_W − 1) is written, the tail wraps to 0.
- R4: The ring is full when (tail + 1) mod 2^PTR_W equals head. An event that arrives while logging is on and the ring is full is dropped with no memory write and no tail change, and it sets the overflow flag (status bit 2).
- R5: Setting the overflow flag never pulses the interrupt output and leaves the entry-written flag (status bit 1) unchanged, so overflow can be set while that flag is clear.
- R6: Every entry write sets the entry-written flag. The interrupt output pulses high for one cycle, in the same cycle as the memory write, only if that flag was 0 and the interrupt switch (control bit 1) is 1.
- R7: Status bits 1 and 2 clear when 1 is written to them. Writing 0 to either bit leaves it unchanged.
- R8: When the logging switch (control bit 0) is cleared, no new event is accepted. The run flag (status bit 0) stays 1 while a write is still pending and drops to 0 once it has been issued. Events that arrive while logging is off are dropped without setting the overflow flag.
- R9: Writes to base (address 2), head (address 3) and tail (address 4) take effect only while the run flag is 0, and are ignored otherwise.
- R10: Setting the logging switch resumes logging from the current head and tail. The same control write sets or clears the interrupt switch independently.
- R11: Register reads are registered. reg_rdata shows the word at reg_addr (control at 0, status at 1) one cycle after reg_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_tag | input | TAG_W | Guest interrupt tag of the event |
| mem_we | output | 1 | Memory write strobe, one cycle per entry |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_data | output | DATA_W | Entry data (zero-extended tag) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Registered read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A table of eight back-to-back events fills the empty ring from slot 0. The table separates the first write, which pulses the interrupt, from the later writes, which only set an already-set flag, and both from the eighth event, which meets a full ring. Further events cover a full ring with the entry-written flag cleared, logging turned off, a wrap from the last slot after a head and tail relocation, writes with the interrupt switch off and then on, and an event that coincides with the stopping write. Together these tell an accepted write apart from an overflow drop and from a silent drop.

// File: rtl/tglog_pkg.sv
package tglog_pkg;
  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_BASE = 3'd2,
    RA_HEAD = 3'd3,
    RA_TAIL = 3'd4
  } reg_addr_e;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_IE_BIT = 1;
  localparam int ST_RUN_BIT  = 0;
  localparam int ST_INT_BIT  = 1;
  localparam int ST_OVF_BIT  = 2;
endpackage

// File: rtl/tglog_ptr.sv
// Head/tail ring pointers with full detection.
module tglog_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_head_we,
  input  logic             sw_tail_we,
  input  logic [PTR_W-1:0] sw_data,
  input  logic             adv,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             full
);
  logic [PTR_W-1:0] tail_inc;

  // Power-of-two depth: natural wrap gives the modulo.
  assign tail_inc = tail + 1'b1;
  assign full     = (tail_inc == head);

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (sw_head_we) head <= sw_data;
      if (adv)             tail <= tail_inc;
      else if (sw_tail_we) tail <= sw_data;
    end
  end
endmodule

// File: rtl/tglog_wstage.sv
// Registered single-beat memory write stage.
module tglog_wstage #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 16,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [PTR_W-1:0]  slot,
  input  logic [TAG_W-1:0]  tag,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int ENTRY_BYTES = DATA_W / 8;
  localparam int OFF_SH      = $clog2(ENTRY_BYTES);

  logic [ADDR_W-1:0] addr_c;
  assign addr_c = base + (ADDR_W'(slot) << OFF_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= go;
      if (go) begin
        mem_addr <= addr_c;
        mem_data <= DATA_W'(tag);
      end
    end
  end
endmodule

// File: rtl/tglog_writer.sv
module tglog_writer
  import tglog_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [TAG_W-1:0]  evt_tag,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              irq
);
  logic              log_en_q, irq_en_q, int_q, ovf_q;
  logic [ADDR_W-1:0] base_q;
  logic [PTR_W-1:0]  head, tail;
  logic              full, run, accept, drop_ovf, cfg_ok;
  logic              wr_ctrl, wr_stat;

  assign run      = log_en_q | mem_we;
  assign accept   = evt_valid & log_en_q & ~full;
  assign drop_ovf = evt_valid & log_en_q & full;
  assign cfg_ok   = reg_we & ~run;
  assign wr_ctrl  = reg_we & (reg_addr == RA_CTRL);
  assign wr_stat  = reg_we & (reg_addr == RA_STAT);

  tglog_ptr #(.PTR_W(PTR_W)) ptr_i (
    .clk        (clk),
    .rst        (rst),
    .sw_head_we (cfg_ok & (reg_addr == RA_HEAD)),
    .sw_tail_we (cfg_ok & (reg_addr == RA_TAIL)),
    .sw_data    (reg_wdata[PTR_W-1:0]),
    .adv        (accept),
    .head       (head),
    .tail       (tail),
    .full       (full)
  );

  tglog_wstage #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .PTR_W  (PTR_W)
  ) wst_i (
    .clk      (clk),
    .rst      (rst),
    .go       (accept),
    .base     (base_q),
    .slot     (tail),
    .tag      (evt_tag),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_data (mem_data)
  );

  // Control, base and status flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      log_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      base_q   <= '0;
      int_q    <= 1'b0;
      ovf_q    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        log_en_q <= reg_wdata[CTRL_EN_BIT];
        irq_en_q <= reg_wdata[CTRL_IE_BIT];
      end
      if (cfg_ok && reg_addr == RA_BASE) base_q <= reg_wdata;
      // Set takes priority over a same-cycle write-one-to-clear.
      if (accept)                                int_q <= 1'b1;
      else if (wr_stat && reg_wdata[ST_INT_BIT]) int_q <= 1'b0;
      if (drop_ovf)                              ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata[ST_OVF_BIT]) ovf_q <= 1'b0;
      irq <= accept & ~int_q & irq_en_q;
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        RA_CTRL: begin
          reg_rdata[CTRL_EN_BIT] <= log_en_q;
          reg_rdata[CTRL_IE_BIT] <= irq_en_q;
        end
        RA_STAT: begin
          reg_rdata[ST_RUN_BIT] <= run;
          reg_rdata[ST_INT_BIT] <= int_q;
          reg_rdata[ST_OVF_BIT] <= ovf_q;
        end
        RA_BASE: reg_rdata <= base_q;
        RA_HEAD: reg_rdata <= ADDR_W'(head);
        RA_TAIL: reg_rdata <= ADDR_W'(tail);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tglog_chk.sv
module tglog_chk (
  input logic clk,
  input logic rst,
  input logic evt_valid,
  input logic irq,
  input logic mem_we,
  input logic log_en,
  input logic irq_en,
  input logic ovf_st
);
  // R5
  ovf_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_st) |-> !irq);

  // R6
  irq_has_write_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> mem_we);

  // R6
  irq_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R8
  write_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(log_en));

  // R8
  off_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !log_en) |=> !$rose(ovf_st));
endmodule

bind tglog_writer tglog_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .evt_valid (evt_valid),
  .irq       (irq),
  .mem_we    (mem_we),
  .log_en    (log_en_q),
  .irq_en    (irq_en_q),
  .ovf_st    (ovf_q)
);

// File: tb/tglog_writer_tb_top.sv
module tglog_writer_tb_top;
  localparam int TAG_W = 16, DATA_W = 32, ADDR_W = 32, PTR_W = 3;
  localparam int NVEC = 8;
  // {tag, expect write, expect irq, expect address}
  localparam logic [49:0] VEC [0:NVEC-1] = '{
    {16'h1111, 1'b1, 1'b1, 32'h0000_1000},
    {16'h2222, 1'b1, 1'b0, 32'h0000_1004},
    {16'h3333, 1'b1, 1'b0, 32'h0000_1008},
    {16'h4444, 1'b1, 1'b0, 32'h0000_100C},
    {16'h5555, 1'b1, 1'b0, 32'h0000_1010},
    {16'h6666, 1'b1, 1'b0, 32'h0000_1014},
    {16'h7777, 1'b1, 1'b0, 32'h0000_1018},
    {16'h8888, 1'b0, 1'b0, 32'h0000_0000}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              evt_valid = 1'b0;
  logic [TAG_W-1:0]  evt_tag = '0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = 3'd0;
  logic [ADDR_W-1:0] reg_wdata = '0;
  logic [ADDR_W-1:0] reg_rdata;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tglog_writer #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_tag(evt_tag),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [ADDR_W-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [ADDR_W-1:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send(input string req, input logic [TAG_W-1:0] tag, input logic exp_wr,
                      input logic exp_irq, input logic [ADDR_W-1:0] exp_addr);
    evt_valid = 1'b1; evt_tag = tag;
    @(negedge clk);
    evt_valid = 1'b0;
    chk(req, 64'(mem_we), 64'(exp_wr));
    if (exp_wr) begin
      chk(req, 64'(mem_addr), 64'(exp_addr));
      chk(req, 64'(mem_data), 64'(tag));
    end
    chk(req, 64'(irq), 64'(exp_irq));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mem_we", 64'(mem_we), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), rd);
      chk("R1 reg", 64'(rd), 64'd0);
    end

    // Configure while stopped, then enable with interrupts.
    reg_write(3'd2, 32'h1000);
    reg_write(3'd0, 32'h3);
    // R9 writes ignored while running
    reg_write(3'd4, 32'h5);
    reg_write(3'd2, 32'h2000);
    reg_read(3'd4, rd); chk("R9 tail kept", 64'(rd), 64'd0);
    reg_read(3'd2, rd); chk("R9 base kept", 64'(rd), 64'h1000);
    reg_read(3'd0, rd); chk("R11 ctrl read", 64'(rd), 64'h3);

    // Table: fill ring (R2, R6), eighth event overflows (R4).
    for (int i = 0; i < NVEC; i++)
      send("R2/R4/R6 table", VEC[i][49:34], VEC[i][33], VEC[i][32], VEC[i][31:0]);

    reg_read(3'd1, rd); chk("R4 stat run+int+ovf", 64'(rd), 64'h7);
    reg_read(3'd4, rd); chk("R4 tail unchanged", 64'(rd), 64'd7);

    // R7 W1C
    reg_write(3'd1, 32'h6);
    reg_read(3'd1, rd); chk("R7 clear both", 64'(rd), 64'h1);
    // R5 overflow with int clear
    send("R5 overflow no irq", 16'hABCD, 1'b0, 1'b0, '0);
    reg_read(3'd1, rd); chk("R5 ovf without int", 64'(rd), 64'h5);
    reg_write(3'd1, 32'h0);
    reg_read(3'd1, rd); chk("R7 write zero no effect", 64'(rd), 64'h5);
    reg_write(3'd1, 32'h4);
    reg_read(3'd1, rd); chk("R7 clear ovf", 64'(rd), 64'h1);

    // R8 stop
    reg_write(3'd0, 32'h0);
    reg_read(3'd1, rd); chk("R8 run dropped", 64'(rd), 64'h0);
    send("R8 disabled drop", 16'h0F0F, 1'b0, 1'b0, '0);
    reg_read(3'd1, rd); chk("R8 no ovf when off", 64'(rd), 64'h0);

    // R9 accepted while stopped
    reg_write(3'd3, 32'h6);
    reg_read(3'd3, rd); chk("R9 head written", 64'(rd), 64'd6);

    // R10 restart without interrupts, R3 wrap
    reg_write(3'd0, 32'h1);
    send("R6 irq off", 16'h9999, 1'b1, 1'b0, 32'h101C);
    reg_read(3'd4, rd); chk("R3 tail wrap", 64'(rd), 64'd0);
    reg_read(3'd1, rd); chk("R6 int set", 64'(rd), 64'h3);
    send("R3 slot zero", 16'hAAAA, 1'b1, 1'b0, 32'h1000);
    reg_write(3'd1, 32'h2);
    reg_write(3'd0, 32'h3);
    send("R10 irq enabled", 16'hBBBB, 1'b1, 1'b1, 32'h1004);

    // R8 stop with a write pending
    evt_valid = 1'b1; evt_tag = 16'hCCCC;
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
    @(negedge clk);
    evt_valid = 1'b0; reg_we = 1'b0; reg_addr = 3'd1;
    chk("R8 last write", 64'(mem_we), 64'd1);
    chk("R8 last addr", 64'(mem_addr), 64'h1008);
    @(negedge clk);
    chk("R8 run while pending", 64'(reg_rdata[0]), 64'd1);
    @(negedge clk);
    chk("R8 run low after", 64'(reg_rdata[0]), 64'd0);
    reg_read(3'd0, rd); chk("R11 ctrl cleared", 64'(rd), 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule